// File: doc/BRIEF.md
# Clock Power-Save Rate Controller with Automatic Switchback

This block produces the clock-enable strobes that pace a small microcontroller's core, its general peripherals and its display logic, all from one high-frequency clock. Software writes a three-bit control word. One bit selects a power-save mode in which the core and the general peripherals advance only once every 256 high-frequency cycles. Outside that mode they advance on every cycle.

A second control bit arms automatic recovery. While both the power-save bit and the recovery bit are 1, any one of a fixed set of I/O or alarm events makes the hardware clear the power-save bit. Full speed then returns without software taking part. The events are:

- an enabled external interrupt;
- a falling edge on a serial receive pin whose receiver is enabled;
- a write to a serial transmit buffer;
- an SPI data write in master mode;
- a falling slave select in slave mode;
- an I2C START interrupt;
- a supply-monitor interrupt;
- a real-time-clock time-of-day alarm or subsecond alarm.

The display enable ignores the power-save mode. It follows a divide-by-512 tick or a synchronised 32 kHz input, chosen by the third control bit.

Top module: `clkpm_switchback`

## Requirements
- R1: After reset the control word is 0: save_mode, swb_enable and disp_src all read 0, and core_ce and periph_ce are 1 on every cycle.
- R2: A cycle with wr_en high loads the control word on the next clock edge from wr_data, where bit 0 is the power-save bit, bit 1 is the switchback-enable bit and bit 2 is the display source select.
- R3: While save_mode is 1, core_ce and periph_ce are high for one cycle in every 256. The first pulse comes in the 256th cycle after the edge that set save_mode. The two outputs are always equal.
- R4: When save_mode goes to 0, core_ce is 1 from the very next cycle and stays 1 until save_mode is set again.
- R5: With swb_enable at 0, no event input changes save_mode.
- R6: With swb_enable and save_mode both 1, any of the following clears save_mode on the next clock edge, including in the middle of a 256-cycle period: a pulse on an external interrupt bit whose enable bit is set, a tx_buf_wr bit, spi_data_wr while spi_enable and spi_master are 1, i2c_start_irq, svm_irq, rtc_tod_alarm or rtc_subsec_alarm. Gated events whose enable conditions are false have no effect.
- R7: The pins rxd and spi_ssel_n pass through a two-flop synchronizer and then an edge detector. A falling edge on rxd[i] while rx_enable[i] is 1, or on spi_ssel_n while spi_enable is 1 and spi_master is 0, clears save_mode on the third clock edge after the pin changes. When those conditions are not met, the edge has no effect.
- R8: If a write that sets the power-save bit coincides with an event while swb_enable is 1, save_mode reads back 0.
- R9: Hardware never changes swb_enable. Only a write changes it.
- R10: After a switchback, the 256-cycle count restarts from zero. On the next entry the first pulse is again in the 256th cycle.
- R11: With disp_src at 0, disp_ce pulses once every 512 cycles from a free-running count, whatever the value of save_mode. With disp_src at 1, disp_ce pulses for one cycle on the second clock edge after each rising edge of clk32_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 3 | Control word: bit0 power-save, bit1 switchback enable, bit2 display source |
| save_mode | output | 1 | Power-save bit readback |
| swb_enable | output | 1 | Switchback-enable bit readback |
| disp_src | output | 1 | Display source select readback |
| ext_irq | input | N_EXT | External interrupt conditions |
| ext_irq_en | input | N_EXT | External interrupt enables |
| rxd | input | N_UART | Serial receive pins (asynchronous, idle high) |
| rx_enable | input | N_UART | Receiver enables |
| tx_buf_wr | input | N_UART | Transmit buffer write strobes |
| spi_enable | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI master mode (0 = slave) |
| spi_data_wr | input | 1 | SPI data register write strobe |
| spi_ssel_n | input | 1 | SPI slave select pin (asynchronous, active low) |
| i2c_start_irq | input | 1 | I2C START interrupt |
| svm_irq | input | 1 | Supply-monitor interrupt |
| rtc_tod_alarm | input | 1 | RTC time-of-day alarm |
| rtc_subsec_alarm | input | 1 | RTC subsecond alarm |
| clk32_in | input | 1 | 32 kHz clock (asynchronous) |
| core_ce | output | 1 | Core clock enable |
| periph_ce | output | 1 | General peripheral clock enable |
| disp_ce | output | 1 | Display clock enable |

## Verification
Every result has a fixed delay, counted in edges from the stimulus:

| Stimulus or result | Edges until it shows |
|---|---|
| Control write, synchronous switchback event | 1 |
| Pin-driven switchback (synchronizer plus edge register) | 3 |
| clk32_in rising edge to disp_ce | 2 |
| First core pulse after entering power-save | 255 (the 256th cycle) |
| Spacing of display pulses from the divider | 512 |

The bench drives inputs one time unit after a rising edge and samples one time unit after the edge where the result is due. For the pin paths it also checks the cycle before that edge, to pin down the exact latency. The pulse positions are found by counting cycles from the loading edge and comparing against 255, 511 and a spacing of 512.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  // Control word: the packed layout matches the write data bit positions.
  typedef struct packed {
    logic dsel;  // bit 2
    logic swb;   // bit 1
    logic save;  // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Switchback fires when armed and either already in power-save or being put there.
  function automatic logic sb_clear(input logic trig, input logic swb,
                                    input logic save, input logic set_req);
    return trig & swb & (save | set_req);
  endfunction

  // Enable for a divided domain: every cycle at full rate, terminal count otherwise.
  function automatic logic rate_ce(input logic slow, input logic term);
    return slow ? term : 1'b1;
  endfunction

endpackage

// File: rtl/clkpm_edge_sync.sv
module clkpm_edge_sync #(
  parameter int   STAGES  = 2,
  parameter bit   FALL    = 1'b1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_o
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {SH_W{RST_VAL}};
    else        sh_q <= {sh_q[SH_W-2:0], async_in};
  end

  generate
    if (FALL) begin : g_fall
      assign edge_o = sh_q[STAGES] & ~sh_q[STAGES-1];
    end else begin : g_rise
      assign edge_o = ~sh_q[STAGES] & sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/clkpm_trigger_mux.sv
module clkpm_trigger_mux #(
  parameter int N_EXT       = 4,
  parameter int N_UART      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_EXT-1:0]  ext_irq_en,
  input  logic [N_UART-1:0] rxd,
  input  logic [N_UART-1:0] rx_enable,
  input  logic [N_UART-1:0] tx_buf_wr,
  input  logic              spi_enable,
  input  logic              spi_master,
  input  logic              spi_data_wr,
  input  logic              spi_ssel_n,
  input  logic              i2c_start_irq,
  input  logic              svm_irq,
  input  logic              rtc_tod_alarm,
  input  logic              rtc_subsec_alarm,
  output logic              trig_any
);
  logic [N_UART-1:0] rx_fall;
  logic              ssel_fall;
  logic              t_ext, t_rx, t_tx, t_spim, t_spis, t_misc;

  for (genvar i = 0; i < N_UART; i++) begin : g_rx
    clkpm_edge_sync #(.STAGES(SYNC_STAGES), .FALL(1'b1), .RST_VAL(1'b1)) u_rx_sync (
      .clk(clk), .rst_n(rst_n), .async_in(rxd[i]), .edge_o(rx_fall[i])
    );
  end

  clkpm_edge_sync #(.STAGES(SYNC_STAGES), .FALL(1'b1), .RST_VAL(1'b1)) u_ssel_sync (
    .clk(clk), .rst_n(rst_n), .async_in(spi_ssel_n), .edge_o(ssel_fall)
  );

  always_comb begin
    t_ext  = |(ext_irq & ext_irq_en);
    t_rx   = |(rx_fall & rx_enable);
    t_tx   = |tx_buf_wr;
    t_spim = spi_data_wr & spi_enable & spi_master;
    t_spis = ssel_fall & spi_enable & ~spi_master;
    t_misc = i2c_start_irq | svm_irq | rtc_tod_alarm | rtc_subsec_alarm;
    trig_any = t_ext | t_rx | t_tx | t_spim | t_spis | t_misc;
  end
endmodule

// File: rtl/clkpm_rate_div.sv
module clkpm_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic term
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + DIV_W'(1);
    else          cnt_q <= '0;
  end

  assign term = run & (cnt_q == {DIV_W{1'b1}});
endmodule

// File: rtl/clkpm_ctrl_reg.sv
module clkpm_ctrl_reg
  import clkpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_word,
  input  logic  trig_any,
  output ctrl_t ctrl_q,
  output logic  sb_fire
);
  ctrl_t ctrl_d;

  always_comb begin
    sb_fire = sb_clear(trig_any, ctrl_q.swb, ctrl_q.save, wr_en & wr_word.save);
    ctrl_d  = wr_en ? wr_word : ctrl_q;
    if (sb_fire) ctrl_d.save = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/clkpm_switchback.sv
module clkpm_switchback
  import clkpm_pkg::*;
#(
  parameter int N_EXT        = 4,
  parameter int N_UART       = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int CORE_DIV_W   = 8,
  parameter int DISP_DIV_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_data,
  output logic              save_mode,
  output logic              swb_enable,
  output logic              disp_src,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_EXT-1:0]  ext_irq_en,
  input  logic [N_UART-1:0] rxd,
  input  logic [N_UART-1:0] rx_enable,
  input  logic [N_UART-1:0] tx_buf_wr,
  input  logic              spi_enable,
  input  logic              spi_master,
  input  logic              spi_data_wr,
  input  logic              spi_ssel_n,
  input  logic              i2c_start_irq,
  input  logic              svm_irq,
  input  logic              rtc_tod_alarm,
  input  logic              rtc_subsec_alarm,
  input  logic              clk32_in,
  output logic              core_ce,
  output logic              periph_ce,
  output logic              disp_ce
);
  ctrl_t ctrl_q;
  logic  trig_any;
  logic  sb_fire;
  logic  core_term;
  logic  disp_term;
  logic  clk32_rise;

  clkpm_trigger_mux #(.N_EXT(N_EXT), .N_UART(N_UART), .SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n),
    .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
    .rxd(rxd), .rx_enable(rx_enable), .tx_buf_wr(tx_buf_wr),
    .spi_enable(spi_enable), .spi_master(spi_master),
    .spi_data_wr(spi_data_wr), .spi_ssel_n(spi_ssel_n),
    .i2c_start_irq(i2c_start_irq), .svm_irq(svm_irq),
    .rtc_tod_alarm(rtc_tod_alarm), .rtc_subsec_alarm(rtc_subsec_alarm),
    .trig_any(trig_any)
  );

  clkpm_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(ctrl_t'(wr_data)),
    .trig_any(trig_any), .ctrl_q(ctrl_q), .sb_fire(sb_fire)
  );

  clkpm_rate_div #(.DIV_W(CORE_DIV_W)) u_core_div (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.save), .term(core_term)
  );

  clkpm_rate_div #(.DIV_W(DISP_DIV_W)) u_disp_div (
    .clk(clk), .rst_n(rst_n), .run(1'b1), .term(disp_term)
  );

  clkpm_edge_sync #(.STAGES(SYNC_STAGES), .FALL(1'b0), .RST_VAL(1'b0)) u_clk32_sync (
    .clk(clk), .rst_n(rst_n), .async_in(clk32_in), .edge_o(clk32_rise)
  );

  assign save_mode  = ctrl_q.save;
  assign swb_enable = ctrl_q.swb;
  assign disp_src   = ctrl_q.dsel;
  assign core_ce    = rate_ce(ctrl_q.save, core_term);
  assign periph_ce  = rate_ce(ctrl_q.save, core_term);
  assign disp_ce    = ctrl_q.dsel ? clk32_rise : disp_term;
endmodule

// File: rtl/clkpm_chk.sv
module clkpm_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_set,
  input logic save_mode,
  input logic swb_enable,
  input logic disp_src,
  input logic core_ce,
  input logic periph_ce,
  input logic disp_ce,
  input logic trig_any,
  input logic sb_fire
);
  // R3
  ce_pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_ce == periph_ce);

  // R3
  slow_pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_mode && core_ce && !sb_fire && !wr_en) |=> !core_ce);

  // R4
  full_rate_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(save_mode) |-> core_ce);

  // R5
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_mode && !swb_enable && !wr_en) |=> save_mode);

  // R6
  switchback_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_fire |=> !save_mode);

  // R8
  collision_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_set && trig_any && swb_enable) |=> !save_mode);

  // R9
  swb_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(swb_enable));

  // R11
  disp_div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_src && disp_ce && !wr_en) |=> !disp_ce);
endmodule

bind clkpm_switchback clkpm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_data[0]),
  .save_mode(save_mode), .swb_enable(swb_enable), .disp_src(disp_src),
  .core_ce(core_ce), .periph_ce(periph_ce), .disp_ce(disp_ce),
  .trig_any(trig_any), .sb_fire(sb_fire)
);

// File: tb/clkpm_switchback_bench.sv
`timescale 1ns/1ps
module clkpm_switchback_bench;
  localparam int NE = 4;
  localparam int NU = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic save_mode, swb_enable, disp_src, core_ce, periph_ce, disp_ce;
  logic [NE-1:0] ext_irq = '0, ext_irq_en = '0;
  logic [NU-1:0] rxd = '1, rx_enable = '0, tx_buf_wr = '0;
  logic spi_enable = 0, spi_master = 0, spi_data_wr = 0, spi_ssel_n = 1;
  logic i2c_start_irq = 0, svm_irq = 0, rtc_tod_alarm = 0, rtc_subsec_alarm = 0;
  logic clk32_in = 0;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkpm_switchback u_clkpm_switchback (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .save_mode(save_mode), .swb_enable(swb_enable), .disp_src(disp_src),
    .ext_irq(ext_irq), .ext_irq_en(ext_irq_en), .rxd(rxd), .rx_enable(rx_enable),
    .tx_buf_wr(tx_buf_wr), .spi_enable(spi_enable), .spi_master(spi_master),
    .spi_data_wr(spi_data_wr), .spi_ssel_n(spi_ssel_n),
    .i2c_start_irq(i2c_start_irq), .svm_irq(svm_irq),
    .rtc_tod_alarm(rtc_tod_alarm), .rtc_subsec_alarm(rtc_subsec_alarm),
    .clk32_in(clk32_in), .core_ce(core_ce), .periph_ce(periph_ce), .disp_ce(disp_ce)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  // drive one synchronous event source: 0..7
  task automatic set_evt(input int which, input logic v);
    case (which)
      0: ext_irq[2] = v;
      1: tx_buf_wr[1] = v;
      2: spi_data_wr = v;
      3: i2c_start_irq = v;
      4: svm_irq = v;
      5: rtc_tod_alarm = v;
      6: rtc_subsec_alarm = v;
      default: tx_buf_wr[0] = v;
    endcase
  endtask

  task automatic t_reset();
    chk(save_mode == 0 && swb_enable == 0 && disp_src == 0, "R1 ctrl reset",
        {disp_src, swb_enable, save_mode}, 0);
    chk(core_ce && periph_ce, "R1 full rate after reset", {core_ce, periph_ce}, 3);
    tick(1);
    chk(core_ce == 1, "R1 full rate next cycle", core_ce, 1);
  endtask

  task automatic t_write();
    wr(3'b110);
    chk({disp_src, swb_enable, save_mode} == 3'b110, "R2 write fields",
        {disp_src, swb_enable, save_mode}, 6);
    wr(3'b000);
    chk({disp_src, swb_enable, save_mode} == 3'b000, "R2 write clear",
        {disp_src, swb_enable, save_mode}, 0);
  endtask

  task automatic t_slow_rate();
    int p1 = -1, p2 = -1, mism = 0;
    wr(3'b001);
    for (int k = 0; k < 520; k++) begin
      if (core_ce != periph_ce) mism++;
      if (core_ce) begin
        if (p1 < 0) p1 = k; else if (p2 < 0) p2 = k;
      end
      tick(1);
    end
    chk(p1 == 255, "R3 first slow pulse", p1, 255);
    chk(p2 == 511, "R3 second slow pulse", p2, 511);
    chk(mism == 0, "R3 core/periph equal", mism, 0);
    wr(3'b000);
    chk(core_ce == 1, "R4 full rate after write clear", core_ce, 1);
    tick(3);
    chk(core_ce == 1, "R4 stays full rate", core_ce, 1);
  endtask

  task automatic t_unarmed();
    wr(3'b001);
    ext_irq_en = '1;
    for (int w = 0; w < 8; w++) begin
      set_evt(w, 1'b1); tick(1); set_evt(w, 1'b0);
    end
    rx_enable = '1; rxd[0] = 0; tick(4); rxd[0] = 1; tick(4);
    chk(save_mode == 1, "R5 no switchback when unarmed", save_mode, 1);
    ext_irq_en = '0; rx_enable = '0;
    wr(3'b000);
  endtask

  task automatic t_sync_events();
    ext_irq_en = 4'b0100;
    spi_enable = 1; spi_master = 1;
    for (int w = 0; w < 8; w++) begin
      wr(3'b011);
      tick(10);
      set_evt(w, 1'b1); tick(1); set_evt(w, 1'b0);
      chk(save_mode == 0, $sformatf("R6 event %0d clears", w), save_mode, 0);
      chk(core_ce == 1, $sformatf("R6 event %0d full rate", w), core_ce, 1);
      chk(swb_enable == 1, $sformatf("R9 event %0d keeps swb", w), swb_enable, 1);
    end
    // gated sources with their enables off
    wr(3'b011);
    ext_irq_en = 4'b0000; ext_irq[2] = 1; tick(1); ext_irq[2] = 0;
    spi_master = 0; spi_data_wr = 1; tick(1); spi_data_wr = 0;
    tick(1);
    chk(save_mode == 1, "R6 gated events ignored", save_mode, 1);
    spi_enable = 0;
    wr(3'b010);
  endtask

  task automatic t_pins();
    wr(3'b011);
    rx_enable = 2'b01;
    rxd[0] = 0; tick(2);
    chk(save_mode == 1, "R7 rx not yet after 2 edges", save_mode, 1);
    tick(1);
    chk(save_mode == 0, "R7 rx clears on 3rd edge", save_mode, 0);
    rxd[0] = 1; tick(4);
    wr(3'b011);
    rxd[1] = 0; tick(5);
    chk(save_mode == 1, "R7 disabled receiver ignored", save_mode, 1);
    rxd[1] = 1; tick(4);
    spi_enable = 1; spi_master = 0;
    spi_ssel_n = 0; tick(2);
    chk(save_mode == 1, "R7 ssel not yet after 2 edges", save_mode, 1);
    tick(1);
    chk(save_mode == 0, "R7 ssel clears on 3rd edge", save_mode, 0);
    spi_ssel_n = 1; tick(4);
    wr(3'b011);
    spi_master = 1; spi_ssel_n = 0; tick(5);
    chk(save_mode == 1, "R7 ssel in master mode ignored", save_mode, 1);
    spi_ssel_n = 1; spi_enable = 0; rx_enable = '0; tick(4);
    wr(3'b010);
  endtask

  task automatic t_collision();
    wr(3'b010);
    wr_en = 1; wr_data = 3'b011; svm_irq = 1;
    tick(1);
    wr_en = 0; svm_irq = 0;
    chk(save_mode == 0, "R8 event wins over set", save_mode, 0);
    chk(swb_enable == 1, "R8 swb kept", swb_enable, 1);
  endtask

  task automatic t_restart();
    int p1 = -1;
    wr(3'b011);
    tick(100);
    rtc_tod_alarm = 1; tick(1); rtc_tod_alarm = 0;
    chk(core_ce == 1, "R10 mid-period switchback full rate", core_ce, 1);
    wr(3'b011);
    for (int k = 0; k < 300; k++) begin
      if (core_ce && p1 < 0) p1 = k;
      tick(1);
    end
    chk(p1 == 255, "R10 count restarts", p1, 255);
    wr(3'b000);
  endtask

  task automatic t_display(input logic [2:0] mode, input string tag);
    int p1 = -1, p2 = -1;
    wr(mode);
    for (int k = 0; k < 1100; k++) begin
      if (disp_ce) begin
        if (p1 < 0) p1 = k; else if (p2 < 0) p2 = k;
      end
      tick(1);
    end
    chk(p1 >= 0 && (p2 - p1) == 512, tag, p2 - p1, 512);
  endtask

  task automatic t_disp32();
    wr(3'b100);
    tick(3);
    chk(disp_ce == 0, "R11 no pulse while clk32 steady", disp_ce, 0);
    clk32_in = 1; tick(1);
    chk(disp_ce == 0, "R11 clk32 after 1 edge", disp_ce, 0);
    tick(1);
    chk(disp_ce == 1, "R11 clk32 pulse after 2 edges", disp_ce, 1);
    tick(1);
    chk(disp_ce == 0, "R11 clk32 pulse one cycle", disp_ce, 0);
    clk32_in = 0; tick(4);
    chk(disp_ce == 0, "R11 falling clk32 ignored", disp_ce, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_write();
    t_slow_rate();
    t_unarmed();
    t_sync_events();
    t_pins();
    t_collision();
    t_restart();
    t_display(3'b000, "R11 div512 full rate");
    t_display(3'b001, "R11 div512 in power-save");
    t_disp32();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule